// File: doc/BRIEF.md
# Two-Phase Transition Handshake Link

This block carries single data words between two unrelated clock domains with a non-return-to-zero request/acknowledge pair. A transfer is one edge on the request line, answered by one edge on the acknowledge line. Either polarity of edge counts. No second pair of edges returns the lines to zero. Both ends therefore store a phase bit and detect a new event when the synchronized line no longer matches it.

On the sending side, a one-cycle `send_i` launches a word while the link is idle. The word is captured and held on the crossing bus until the acknowledge returns. Then `done_o` pulses once and the link accepts the next word. On the receiving side, the request is resynchronized and detected by phase comparison. The word is latched and announced with a one-cycle `valid_o`. The acknowledge is toggled once the local consumer raises `ready_i`.

Top module: `tph_link`

## Requirements
- R1: While either reset is asserted and right after it, `req_line_o`, `ack_line_o`, `busy_o`, `done_o` and `valid_o` are all 0, so no transfer is pending.
- R2: A `send_i` pulse while `busy_o` is 0 inverts `req_line_o` at the next `clk_a_i` edge. `busy_o` reads 1 from that same edge on.
- R3: A `send_i` while `busy_o` is 1 is ignored: `req_line_o` stays put and no additional `valid_o` pulse appears.
- R4: The word on `data_i` in the launching cycle is the word delivered. Later changes of `data_i` during the transfer do not alter it.
- R5: The receiver sees the request through a synchronizer of `SYNC_STAGES` (at least 2) flops. It then raises `valid_o` for exactly one `clk_b_i` cycle, with `data_o` holding the launched word.
- R6: `ack_line_o` changes only after the word was announced and only while `ready_i` is 1. Afterwards it equals `req_line_o`.
- R7: When the synchronized acknowledge matches the request phase, `done_o` is 1 for exactly one `clk_a_i` cycle. `busy_o` is 0 in that same cycle.
- R8: Transfers alternate polarity: the first uses rising edges of request and acknowledge, the next uses falling edges. Each transfer costs exactly one edge on each line.
- R9: A `send_i` in the cycle where `done_o` is 1 is accepted, so transfers can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Sender clock |
| rst_a_ni | input | 1 | Sender async reset, active low |
| send_i | input | 1 | Launch strobe |
| data_i | input | DATA_W | Word to send |
| busy_o | output | 1 | Transfer in flight |
| done_o | output | 1 | One-cycle completion strobe |
| req_line_o | output | 1 | Request phase line |
| clk_b_i | input | 1 | Receiver clock |
| rst_b_ni | input | 1 | Receiver async reset, active low |
| ready_i | input | 1 | Consumer ready to acknowledge |
| valid_o | output | 1 | One-cycle word-arrived strobe |
| data_o | output | DATA_W | Received word |
| ack_line_o | output | 1 | Acknowledge phase line |

## Verification
The bench builds the link with `DATA_W` = 12 and the default two synchronizer stages. It runs the two clocks at 5 ns and 7 ns, so the edges of the two domains drift against each other from one transfer to the next. The 12-bit words use patterns with both halves set differently, which exposes a partly captured or re-captured word. Two flops per direction keep the round trip short, so several transfers of both polarities, a stalled consumer and a back-to-back launch all fit in a brief run.

// File: rtl/tph_pkg.sv
package tph_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // a new event exists when the seen line level departs from the stored phase
  function automatic logic phase_moved(logic line_lvl, logic phase_lvl);
    return line_lvl ^ phase_lvl;
  endfunction
endpackage

// File: rtl/tph_sync.sv
module tph_sync #(
  parameter int unsigned STAGES = tph_pkg::SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tph_requester.sv
module tph_requester import tph_pkg::*; #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              ack_s;
  logic              req_q;
  logic              busy_q;
  logic [DATA_W-1:0] data_q;
  logic              launch;

  tph_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  assign busy_o = phase_moved(req_q, ack_s);
  assign launch = send_i & ~busy_o;
  assign done_o = busy_q & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      data_q <= '0;
    end else begin
      busy_q <= busy_o;
      if (launch) begin
        req_q  <= ~req_q;
        data_q <= data_i;
      end
    end
  end

  assign req_o  = req_q;
  assign data_o = data_q;

  AST_REQ_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (req_q == $past(req_q))); // R3
  AST_DATA_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(data_q)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> busy_o); // R2
endmodule

// File: rtl/tph_responder.sv
module tph_responder import tph_pkg::*; #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              ack_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              req_s;
  logic              seen_q;   // phase of the last request taken
  logic              ack_q;    // phase last acknowledged
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              take;
  logic              pending;

  tph_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  assign take    = phase_moved(req_s, seen_q);
  assign pending = phase_moved(seen_q, ack_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= take;
      if (take) begin
        seen_q <= req_s;
        data_q <= data_i;
      end
      if (pending && ready_i) ack_q <= seen_q;
    end
  end

  assign ack_o   = ack_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
  AST_ACK_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q != $past(ack_q)) |-> ($past(ready_i) && $past(seen_q != ack_q))); // R6
  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> !pending); // R8
endmodule

// File: rtl/tph_link.sv
module tph_link import tph_pkg::*; #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_a_i,
  input  logic              rst_a_ni,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_line_o,
  input  logic              clk_b_i,
  input  logic              rst_b_ni,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ack_line_o
);
  logic [DATA_W-1:0] xfer_data;
  logic              req_w;
  logic              ack_w;

  tph_requester #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk_i (clk_a_i),
    .rst_ni(rst_a_ni),
    .send_i(send_i),
    .data_i(data_i),
    .ack_i (ack_w),
    .req_o (req_w),
    .data_o(xfer_data),
    .busy_o(busy_o),
    .done_o(done_o)
  );

  tph_responder #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rsp (
    .clk_i  (clk_b_i),
    .rst_ni (rst_b_ni),
    .req_i  (req_w),
    .data_i (xfer_data),
    .ready_i(ready_i),
    .ack_o  (ack_w),
    .valid_o(valid_o),
    .data_o (data_o)
  );

  assign req_line_o = req_w;
  assign ack_line_o = ack_w;
endmodule

// File: tb/tph_link_test.sv
`timescale 1ns/1ps
module tph_link_test;
  localparam int DW = 12;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic send = 1'b0, ready = 1'b0;
  logic [DW-1:0] din = '0;
  logic busy, done, req_line, valid, ack_line;
  logic [DW-1:0] dout;

  int checks = 0, errors = 0;
  int req_edges = 0, ack_edges = 0, valid_cnt = 0;
  logic req_prev = 1'b0, ack_prev = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  tph_link #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk_a_i(clk_a), .rst_a_ni(rst_a_n), .send_i(send), .data_i(din),
    .busy_o(busy), .done_o(done), .req_line_o(req_line),
    .clk_b_i(clk_b), .rst_b_ni(rst_b_n), .ready_i(ready),
    .valid_o(valid), .data_o(dout), .ack_line_o(ack_line)
  );

  always @(negedge clk_a) if (rst_a_n) begin
    if (req_line !== req_prev) req_edges++;
    req_prev = req_line;
  end
  always @(negedge clk_b) if (rst_b_n) begin
    if (ack_line !== ack_prev) ack_edges++;
    ack_prev = ack_line;
    if (valid === 1'b1) valid_cnt++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(string req, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk_b);
      if (valid === 1'b1) seen = 1'b1;
    end
    chk(seen, req, 0, 1);
  endtask

  task automatic wait_ack(logic lvl, string req);
    bit seen = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk_b);
      if (ack_line === lvl) seen = 1'b1;
    end
    chk(seen, req, int'(ack_line), int'(lvl));
  endtask

  task automatic wait_done(string req);
    bit seen = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk_a);
      if (done === 1'b1) seen = 1'b1;
    end
    chk(seen, req, 0, 1);
  endtask

  task automatic launch(logic [DW-1:0] w);
    din = w; send = 1'b1;
    @(negedge clk_a);
    send = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_line === 1'b0 && ack_line === 1'b0, "R1 lines", {req_line, ack_line}, 0);
    chk(busy === 1'b0 && done === 1'b0 && valid === 1'b0, "R1 strobes", {busy, done, valid}, 0);
  endtask

  // rising-polarity transfer with a stalled consumer
  task automatic t_first();
    bit seen;
    int vc;
    @(negedge clk_a);
    launch(12'hA5C);
    chk(req_line === 1'b1, "R2 R8 req rises", int'(req_line), 1);
    chk(busy === 1'b1, "R2 busy", int'(busy), 1);
    din = 12'h3F0;                       // R4 change after launch
    wait_valid("R5 valid seen", seen);
    chk(dout === 12'hA5C, "R4 R5 data", int'(dout), 'hA5C);
    @(negedge clk_b);
    chk(valid === 1'b0, "R5 single pulse", int'(valid), 0);
    vc = valid_cnt;
    @(negedge clk_a);
    launch(12'h555);                     // R3 send while busy
    chk(req_line === 1'b1, "R3 req held", int'(req_line), 1);
    repeat (12) @(negedge clk_b);
    chk(ack_line === 1'b0, "R6 no ack without ready", int'(ack_line), 0);
    chk(busy === 1'b1, "R6 still busy", int'(busy), 1);
    chk(valid_cnt == vc, "R3 no extra valid", valid_cnt, vc);
    chk(dout === 12'hA5C, "R3 R4 data kept", int'(dout), 'hA5C);
    @(negedge clk_b);
    ready = 1'b1;
    wait_ack(1'b1, "R6 R8 ack rises");
    ready = 1'b0;
    wait_done("R7 done");
    chk(busy === 1'b0, "R7 busy low with done", int'(busy), 0);
    @(negedge clk_a);
    chk(done === 1'b0, "R7 done single", int'(done), 1'b0);
    chk(req_edges == 1 && ack_edges == 1, "R8 one edge each", req_edges * 16 + ack_edges, 'h11);
  endtask

  // falling-polarity transfer, then a back-to-back launch on done
  task automatic t_second();
    bit seen;
    ready = 1'b1;
    @(negedge clk_a);
    launch(12'h1B7);
    chk(req_line === 1'b0, "R8 req falls", int'(req_line), 0);
    wait_valid("R5 second valid", seen);
    chk(dout === 12'h1B7, "R5 second data", int'(dout), 'h1B7);
    wait_ack(1'b0, "R8 ack falls");
    wait_done("R7 second done");
    din = 12'hE42; send = 1'b1;          // R9 launch in done cycle
    @(negedge clk_a);
    send = 1'b0;
    chk(req_line === 1'b1 && busy === 1'b1, "R9 back to back", {req_line, busy}, 3);
    wait_valid("R9 third valid", seen);
    chk(dout === 12'hE42, "R9 third data", int'(dout), 'hE42);
    wait_done("R9 third done");
    chk(ack_line === req_line, "R6 lines agree", int'(ack_line), int'(req_line));
    chk(req_edges == 3 && ack_edges == 3, "R8 edge totals", req_edges * 16 + ack_edges, 'h33);
    chk(valid_cnt == 3, "R3 R5 valid total", valid_cnt, 3);
  endtask

  initial begin
    #1;
    t_reset();
    #40;
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    @(negedge clk_a);
    t_reset();
    t_first();
    t_second();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule